// File: doc/BRIEF.md
# Indirect Program Register Loader

This block holds six 10-bit clock-configuration words, numbered 2 to 7. A host changes them one at a time through a single programming register. A host-bus decoder forwards register write strobes to the block. A programming write carries a word number and a value. A ready flag tells the host when the next programming write may be made. After each accepted write the flag stays low for a fixed number of clocks, which stands for internal processing time. A write made while the flag is low, or one that names a word that does not exist, is dropped and sets a sticky error bit.

Accepted words go into a staging copy first. They reach the live outputs in two groups, and each group has its own commit rule:

- Words 2 and 3 move together when word 3 is written.
- Words 4 to 7 move when the operating mode input enters receive or transmit.

A strap input picks one of two built-in default sets, one for each reference clock. Reset loads that set into both the staging copy and the live copy. The clock dividers that use the words are outside this block.

Top module: `ipl_loader`

## Requirements
- R1: While reset is held with `strap_fast`=1, both copies load the fast set: words 2..7 = 0x018, 0x088, 0x040, 0x200, 0x140, 0x008. After reset, `prog_ready`=1 and `prog_err`=0.
- R2: With `strap_fast`=0, reset loads the slow set into both copies: words 2..7 = 0x017, 0x085, 0x024, 0x1E0, 0x140, 0x008.
- R3: A programming write is accepted when `prog_ready`=1 at the clock edge and the word number is 2..7. After the accepting edge, `prog_ready` reads 0 for exactly BUSY_CYC (default 4) cycles and then returns to 1.
- R4: A programming write made while `prog_ready`=0 has no effect on either copy and does not restart the busy count. It sets `prog_err`, which then stays 1 until reset.
- R5: A programming write whose word number is 0 or 1 changes nothing and leaves `prog_ready` at 1. It sets `prog_err`.
- R6: Live words 2 and 3 change only on an accepted write of word 3. On that write, live word 3 takes the written value and live word 2 takes the staged word 2. Both are visible one cycle after the write edge.
- R7: Live words 4..7 take the staged values on each edge where `op_mode` differs from its value at the previous edge and is receive (2'b01) or transmit (2'b10). Idle (2'b00) and 2'b11 commit nothing. If a write lands on the same edge, the commit uses the staged value from before that write.
- R8: A write strobe whose address is not the programming address (default 0xC8) has no effect on the words, the ready flag or the error bit.
- R9: Field layout:
  - Programming data bits 15:13 hold the word number and bits 9:0 hold the value. Bits 12:10 are ignored.
  - Word k appears on `cfg_words[(k-2)*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fast | input | 1 | Default set select: 1 = 6.144 MHz reference, 0 = 3.6864 MHz reference |
| wr_en | input | 1 | Register write strobe from the host-bus decoder |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | 16 | Write data: word number in bits 15:13, value in bits 9:0 |
| op_mode | input | 2 | Operating mode: 00 idle, 01 receive, 10 transmit, 11 reserved |
| prog_ready | output | 1 | Ready flag; bit 0 of the host's status register |
| prog_err | output | 1 | Sticky flag for a dropped programming write |
| cfg_words | output | 60 | Live words 2..7, word 2 in the low bits |

## Verification
The hardest case is a write that lands in the same cycle as a mode change into receive or transmit. To the host, the new value looks committed, but the live copy must take the older staged value. The bench brings this about by moving the strobe and the mode input together on one falling edge. It then checks the live word after that edge, and again after a later idle-to-transmit change, where the new value must appear.

A rejected write while busy is also hard to observe, because it leaves nothing behind in the live outputs. The bench issues it inside the busy window and then forces a commit. This shows that the staged word kept its old value and that the ready flag rose on the original schedule.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    localparam int WORD_W    = 10;
    localparam int NUM_WORDS = 6;
    localparam int BASE_IDX  = 2;
    localparam int LOW_GROUP = 2;
    localparam int IDX_W     = 3;
    localparam int DATA_W    = 16;
    localparam int SLOT_W    = $clog2(NUM_WORDS);

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] word_bank_t;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RX   = 2'b01,
        MODE_TX   = 2'b10,
        MODE_RSV  = 2'b11
    } op_mode_e;

    // Built-in default set, chosen by the reference-clock strap.
    function automatic word_bank_t strap_defaults(input logic fast_ref);
        word_bank_t b;
        if (fast_ref) begin
            b[0] = 10'h018; b[1] = 10'h088; b[2] = 10'h040;
            b[3] = 10'h200; b[4] = 10'h140; b[5] = 10'h008;
        end else begin
            b[0] = 10'h017; b[1] = 10'h085; b[2] = 10'h024;
            b[3] = 10'h1E0; b[4] = 10'h140; b[5] = 10'h008;
        end
        return b;
    endfunction
endpackage

// File: rtl/ipl_handshake.sv
module ipl_handshake #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic idx_ok,
    output logic ready_o,
    output logic err_o,
    output logic accept_o
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } hs_t;

    hs_t hs_d, hs_q;

    assign ready_o  = (hs_q.cnt == '0);
    assign accept_o = wr_hit && idx_ok && ready_o;
    assign err_o    = hs_q.err;

    always_comb begin
        hs_d = hs_q;
        if (accept_o) begin
            hs_d.cnt = CNT_W'(BUSY_CYC);
        end else if (hs_q.cnt != '0) begin
            hs_d.cnt = hs_q.cnt - CNT_W'(1);
        end
        if (wr_hit && !accept_o) begin
            hs_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end
endmodule

// File: rtl/ipl_word_bank.sv
module ipl_word_bank
    import ipl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_fast,
    input  logic               accept,
    input  logic [IDX_W-1:0]   idx,
    input  logic [WORD_W-1:0]  value,
    input  logic [1:0]         mode,
    output word_bank_t         active_o
);
    typedef struct packed {
        word_bank_t staged;
        word_bank_t active;
        logic [1:0] mode_prev;
    } bank_t;

    bank_t bk_d, bk_q;
    logic              enter;
    logic [SLOT_W-1:0] slot;

    assign enter = (mode != bk_q.mode_prev) &&
                   ((mode == MODE_RX) || (mode == MODE_TX));
    assign slot  = SLOT_W'(idx - IDX_W'(BASE_IDX));

    always_comb begin
        bk_d = bk_q;
        // mode-entry commit of the upper group, from the pre-write staging
        for (int s = LOW_GROUP; s < NUM_WORDS; s++) begin
            if (enter) begin
                bk_d.active[s] = bk_q.staged[s];
            end
        end
        if (accept) begin
            bk_d.staged[slot] = value;
            if (slot == SLOT_W'(LOW_GROUP - 1)) begin
                for (int s = 0; s < LOW_GROUP; s++) begin
                    bk_d.active[s] = (s == LOW_GROUP - 1) ? value : bk_q.staged[s];
                end
            end
        end
        bk_d.mode_prev = mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.staged    <= strap_defaults(strap_fast);
            bk_q.active    <= strap_defaults(strap_fast);
            bk_q.mode_prev <= MODE_IDLE;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign active_o = bk_q.active;
endmodule

// File: rtl/ipl_loader.sv
module ipl_loader
    import ipl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PROG_ADDR = 8'hC8,
    parameter int                BUSY_CYC  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strap_fast,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [1:0]                    op_mode,
    output logic                          prog_ready,
    output logic                          prog_err,
    output logic [NUM_WORDS*WORD_W-1:0]   cfg_words
);
    localparam int IDX_LSB = DATA_W - IDX_W;

    logic             wr_hit;
    logic             idx_ok;
    logic             accept;
    logic [IDX_W-1:0] idx;
    word_bank_t       active;
    logic             unused_pad;

    assign wr_hit     = wr_en && (wr_addr == PROG_ADDR);
    assign idx        = wr_data[DATA_W-1:IDX_LSB];
    assign idx_ok     = (idx >= IDX_W'(BASE_IDX));
    assign unused_pad = ^wr_data[IDX_LSB-1:WORD_W];

    ipl_handshake #(.BUSY_CYC(BUSY_CYC)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .idx_ok   (idx_ok),
        .ready_o  (prog_ready),
        .err_o    (prog_err),
        .accept_o (accept)
    );

    ipl_word_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_fast (strap_fast),
        .accept     (accept),
        .idx        (idx),
        .value      (wr_data[WORD_W-1:0]),
        .mode       (op_mode),
        .active_o   (active)
    );

    assign cfg_words = active;
endmodule

// File: rtl/ipl_loader_chk.sv
module ipl_loader_chk
    import ipl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PROG_ADDR = 8'hC8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [1:0]                  op_mode,
    input logic                        prog_ready,
    input logic                        prog_err,
    input logic [NUM_WORDS*WORD_W-1:0] cfg_words
);
    localparam int LOW_BITS = LOW_GROUP * WORD_W;
    localparam int ALL_BITS = NUM_WORDS * WORD_W;

    logic             hit, acc, enter;
    logic [IDX_W-1:0] n;
    logic [1:0]       mode_seen;
    logic             unused_chk_bits;

    assign n               = wr_data[DATA_W-1:DATA_W-IDX_W];
    assign hit             = wr_en && (wr_addr == PROG_ADDR);
    assign acc             = hit && prog_ready && (n >= IDX_W'(BASE_IDX));
    assign enter           = (op_mode != mode_seen) &&
                             ((op_mode == MODE_RX) || (op_mode == MODE_TX));
    assign unused_chk_bits = ^wr_data[DATA_W-IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_seen <= MODE_IDLE;
        else        mode_seen <= op_mode;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !prog_ready); // R3
    AST_READY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_ready && !acc) |=> prog_ready); // R8
    AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !prog_ready) |=> prog_err); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> prog_err); // R4
    AST_BAD_INDEX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (n < IDX_W'(BASE_IDX))) |=> prog_err); // R5
    AST_LOW_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && (n == IDX_W'(BASE_IDX + LOW_GROUP - 1))) |=> $stable(cfg_words[LOW_BITS-1:0])); // R6
    AST_HIGH_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enter |=> $stable(cfg_words[ALL_BITS-1:LOW_BITS])); // R7
endmodule

bind ipl_loader ipl_loader_chk #(.ADDR_W(ADDR_W), .PROG_ADDR(PROG_ADDR)) u_chk (.*);

// File: tb/ipl_loader_bench.sv
module ipl_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam logic [7:0] PADDR = 8'hC8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_fast = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  op_mode = 2'b00;
    logic        prog_ready, prog_err;
    logic [59:0] cfg_words;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipl_loader u_ipl_loader (
        .clk(clk), .rst_n(rst_n), .strap_fast(strap_fast), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_mode(op_mode),
        .prog_ready(prog_ready), .prog_err(prog_err), .cfg_words(cfg_words)
    );

    // ---------------- behavioural reference model ----------------
    int m_stg [2:7];
    int m_act [2:7];
    int m_busy;
    bit m_err;
    int m_prev;

    function automatic int dflt(bit fast, int k);
        int fa [6] = '{'h018, 'h088, 'h040, 'h200, 'h140, 'h008};
        int sl [6] = '{'h017, 'h085, 'h024, 'h1E0, 'h140, 'h008};
        return fast ? fa[k-2] : sl[k-2];
    endfunction

    function automatic logic [59:0] pack_model();
        logic [59:0] v = '0;
        for (int k = 2; k <= 7; k++) v[(k-2)*10 +: 10] = 10'(m_act[k]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 2; k <= 7; k++) begin
                m_stg[k] = dflt(strap_fast, k);
                m_act[k] = m_stg[k];
            end
            m_busy = 0; m_err = 0; m_prev = 0;
        end else begin
            int nm, ix, vl;
            bit hit;
            nm  = int'(op_mode);
            hit = wr_en && (wr_addr == PADDR);
            ix  = int'(wr_data[15:13]);
            vl  = int'(wr_data[9:0]);
            if (nm != m_prev && (nm == 1 || nm == 2))
                for (int k = 4; k <= 7; k++) m_act[k] = m_stg[k];
            if (hit && m_busy == 0 && ix >= 2) begin
                m_stg[ix] = vl;
                if (ix == 3) begin m_act[2] = m_stg[2]; m_act[3] = vl; end
                m_busy = BUSY;
            end else begin
                if (hit) m_err = 1;
                if (m_busy > 0) m_busy--;
            end
            m_prev = nm;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    bit armed = 0;
    always @(negedge clk) begin
        if (armed && rst_n && !done) begin
            chk(prog_ready == (m_busy == 0), "R3 ready vs model", 64'(prog_ready), 64'(m_busy == 0));
            chk(prog_err == m_err, "R4 err vs model", 64'(prog_err), 64'(m_err));
            chk(cfg_words[19:0] == pack_model() >> 0 & 20'hFFFFF ? 1'b1 : cfg_words[19:0] == pack_model()[19:0],
                "R6 low words vs model", 64'(cfg_words[19:0]), 64'(pack_model()[19:0]));
            chk(cfg_words[59:20] == pack_model()[59:20], "R7 high words vs model",
                64'(cfg_words[59:20]), 64'(pack_model()[59:20]));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [9:0] word(int k);
        return cfg_words[(k-2)*10 +: 10];
    endfunction

    task automatic wr(input logic [7:0] a, input int ix, input logic [9:0] v, input logic [2:0] pad = 3'b000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {3'(ix), pad, v};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setm(input logic [1:0] m);
        @(negedge clk);
        op_mode = m;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!prog_ready) @(negedge clk);
    endtask

    task automatic do_reset(input bit fast);
        @(negedge clk);
        rst_n = 1'b0; strap_fast = fast; op_mode = 2'b00; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        int n;
        do_reset(1'b1);
        armed = 1;
        @(negedge clk);
        // R1 fast defaults
        chk(cfg_words == {10'h008, 10'h140, 10'h200, 10'h040, 10'h088, 10'h018}, "R1 fast defaults",
            64'(cfg_words), 64'({10'h008, 10'h140, 10'h200, 10'h040, 10'h088, 10'h018}));
        chk(prog_ready && !prog_err, "R1 flags after reset", {62'b0, prog_ready, prog_err}, 64'b10);

        // R6 staged word 2 not live yet; R3 busy length
        wr(PADDR, 2, 10'h155);
        chk(word(2) == 10'h018, "R6 word2 held before word3", 64'(word(2)), 64'h018);
        n = 0;
        while (!prog_ready) begin n++; @(negedge clk); end
        chk(n == BUSY, "R3 busy cycles", 64'(n), 64'(BUSY));

        // R6 word3 write commits the pair; R9 ignored pad bits
        wr(PADDR, 3, 10'h2AA, 3'b111);
        chk(word(2) == 10'h155 && word(3) == 10'h2AA, "R6 R9 pair commit",
            64'({word(3), word(2)}), 64'({10'h2AA, 10'h155}));
        wait_ready();

        // R7 upper group waits for mode entry
        wr(PADDR, 5, 10'h3FF);
        wait_ready();
        chk(word(5) == 10'h200, "R7 word5 held in idle", 64'(word(5)), 64'h200);
        setm(2'b01);
        chk(word(5) == 10'h3FF, "R7 commit on receive", 64'(word(5)), 64'h3FF);
        setm(2'b00);
        wr(PADDR, 6, 10'h111);
        wait_ready();
        setm(2'b11);
        chk(word(6) == 10'h140, "R7 reserved mode no commit", 64'(word(6)), 64'h140);
        setm(2'b10);
        chk(word(6) == 10'h111, "R7 commit on transmit", 64'(word(6)), 64'h111);

        // R8 other address ignored
        wr(8'hC6, 7, 10'h0AB);
        chk(prog_ready && !prog_err, "R8 other address flags", {62'b0, prog_ready, prog_err}, 64'b10);
        setm(2'b00); setm(2'b01);
        chk(word(7) == 10'h008, "R8 other address no word change", 64'(word(7)), 64'h008);

        // R7 same-edge write and mode entry
        setm(2'b00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = PADDR; wr_data = {3'd4, 3'b000, 10'h0F0}; op_mode = 2'b10;
        @(negedge clk);
        wr_en = 1'b0;
        chk(word(4) == 10'h040, "R7 same-edge uses old staging", 64'(word(4)), 64'h040);
        wait_ready();
        setm(2'b00); setm(2'b10);
        chk(word(4) == 10'h0F0, "R7 later commit of new value", 64'(word(4)), 64'h0F0);

        // R4 write while busy dropped
        setm(2'b00);
        wr(PADDR, 4, 10'h123);
        wr(PADDR, 7, 10'h321);
        chk(prog_err == 1'b1, "R4 busy write sets err", 64'(prog_err), 64'h1);
        wait_ready();
        setm(2'b01);
        chk(word(7) == 10'h008 && word(4) == 10'h123, "R4 busy write dropped",
            64'({word(7), word(4)}), 64'({10'h008, 10'h123}));
        repeat (3) @(negedge clk);
        chk(prog_err == 1'b1, "R4 err sticky", 64'(prog_err), 64'h1);

        // R5 bad word number
        do_reset(1'b1);
        @(negedge clk);
        wr(PADDR, 1, 10'h3C3);
        chk(prog_err && prog_ready, "R5 bad index err, ready kept", {62'b0, prog_err, prog_ready}, 64'b11);
        wr(PADDR, 0, 10'h3C3);
        chk(cfg_words == {10'h008, 10'h140, 10'h200, 10'h040, 10'h088, 10'h018}, "R5 bad index no change",
            64'(cfg_words), 64'({10'h008, 10'h140, 10'h200, 10'h040, 10'h088, 10'h018}));

        // R2 slow defaults, staging also reloaded
        do_reset(1'b0);
        @(negedge clk);
        chk(cfg_words == {10'h008, 10'h140, 10'h1E0, 10'h024, 10'h085, 10'h017}, "R2 slow defaults",
            64'(cfg_words), 64'({10'h008, 10'h140, 10'h1E0, 10'h024, 10'h085, 10'h017}));
        wr(PADDR, 3, 10'h001);
        chk(word(2) == 10'h017 && word(3) == 10'h001, "R2 staging reloaded",
            64'({word(3), word(2)}), 64'({10'h001, 10'h017}));
        wait_ready();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule